// File: doc/BRIEF.md
# Quadrature Encoder Counter with Trigger Modes

This block turns two asynchronous input lines into a 16-bit position or event count. Each line is resynchronized to the core clock, optionally inverted, and reduced to edge strobes. A 3-bit mode field chooses how those strobes drive the counter:
- x2 decoding on either line;
- x4 decoding on both lines;
- clearing the counter when channel A rises;
- starting a free-running count when channel A rises;
- using channel A's rising edges as the count clock.

The counter wraps between zero and a programmable limit. Each wrap, and each clear, raises a one-cycle update strobe. A direction flag records whether the most recent step went up or down.

The block sits beside a motor or knob interface. Firmware-facing logic elsewhere programs the mode, limit, polarity and enable, and reads the count and direction back.

Top module: `qenc_timer`

## Requirements
- R1: After reset the count is 0, the direction flag is 0 and the update strobe is low.
- R2: In mode 3'b011 every single-line edge of A or B changes the count by one.
  - An A edge counts up when the new A level differs from B.
  - A B edge counts up when the new B level equals A.
  - The new count appears 3 clock cycles after the pin change.
- R3: In mode 3'b001 only A edges step the count (direction as in R2) and B edges are ignored. In mode 3'b010 only B edges step it and A edges are ignored.
- R4: In the encoder modes, a cycle in which both filtered lines change is ignored and leaves the count unchanged.
- R5: Counting up from a value at or above the limit gives 0. Counting down from 0 gives the limit. Each such wrap raises the update strobe for exactly one cycle, together with the new count.
- R6: The direction flag is 0 after an up step and 1 after a down step, and holds between steps.
- R7: With the enable low (and no trigger start in effect), no mode changes the count, except the clear of R8.
- R8: In mode 3'b100 a rising edge of filtered A loads 0 and raises the update strobe, whether or not the enable is set. The direction flag is left unchanged. While enabled, the counter counts up once per clock.
- R9: In mode 3'b110 a rising edge of filtered A starts the counter without clearing it. Counting begins one cycle after the clock edge on which the trigger is seen, and it lasts until the mode changes.
- R10: In mode 3'b111, while enabled, each rising edge of filtered A adds one. Falling edges do nothing.
- R11: Setting a line's invert input makes its inverted level the filtered level, so in mode 3'b111 a falling pin edge on A counts.
- R12: In modes 3'b000 and 3'b101, while enabled, the counter counts up once per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_a_i | input | 1 | Channel A pin, asynchronous |
| ch_b_i | input | 1 | Channel B pin, asynchronous |
| inv_a_i | input | 1 | Invert channel A |
| inv_b_i | input | 1 | Invert channel B |
| cnt_en_i | input | 1 | Counter enable |
| mode_i | input | 3 | Mode select code |
| reload_i | input | CNT_W | Wrap limit (0xFFFF for full range) |
| count_o | output | CNT_W | Current count |
| dir_down_o | output | 1 | 1 when the last step was downward |
| update_o | output | 1 | One-cycle strobe on wrap or clear |

## Verification
A pin change lands in the count 3 clock edges later: two synchronizer stages, then the count register. Changes to the enable or mode act on the very next edge. A trigger start in mode 3'b110 adds one further cycle, because the start flag is registered.

The driver sets every input at the falling clock edge and records each expected item with its due cycle number. The monitor compares items one nanosecond after the falling edge of exactly that cycle, and flags any item that comes due late. Free-running cases are checked at fixed offsets from the enable edge, so each value follows from the count of clock edges alone.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [2:0] {
    MODE_FREE_0   = 3'b000,
    MODE_ENC_A    = 3'b001,
    MODE_ENC_B    = 3'b010,
    MODE_ENC_AB   = 3'b011,
    MODE_TRIG_CLR = 3'b100,
    MODE_FREE_5   = 3'b101,
    MODE_TRIG_RUN = 3'b110,
    MODE_EXT_CLK  = 3'b111
  } qenc_mode_e;

  // Up when the new A level differs from B (A leads B going forward).
  function automatic logic a_edge_up(input logic a_now, input logic b_now);
    return a_now != b_now;
  endfunction

  // Up when the new B level matches A.
  function automatic logic b_edge_up(input logic a_now, input logic b_now);
    return a_now == b_now;
  endfunction

endpackage

// File: rtl/qenc_sync_edge.sv
module qenc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic inv_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= pin_i ^ inv_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       cnt_en_i,
  input  logic       a_lvl_i,
  input  logic       a_rise_i,
  input  logic       a_fall_i,
  input  logic       b_lvl_i,
  input  logic       b_rise_i,
  input  logic       b_fall_i,
  output logic       run_en_o,
  output logic       step_o,
  output logic       down_o,
  output logic       clear_o
);

  qenc_mode_e mode_e;
  logic       a_edge, b_edge;
  logic       started_q;
  logic       step_raw;

  assign mode_e = qenc_mode_e'(mode_i);
  assign a_edge = a_rise_i | a_fall_i;
  assign b_edge = b_rise_i | b_fall_i;

  // Start flag for trigger-run mode; dropped as soon as the mode changes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            started_q <= 1'b0;
    else if (mode_e != MODE_TRIG_RUN)      started_q <= 1'b0;
    else if (a_rise_i)                     started_q <= 1'b1;
  end

  assign run_en_o = cnt_en_i | started_q;

  always_comb begin
    step_raw = 1'b0;
    down_o   = 1'b0;
    clear_o  = 1'b0;
    case (mode_e)
      MODE_ENC_A: begin
        step_raw = a_edge & ~b_edge;
        down_o   = ~a_edge_up(a_lvl_i, b_lvl_i);
      end
      MODE_ENC_B: begin
        step_raw = b_edge & ~a_edge;
        down_o   = ~b_edge_up(a_lvl_i, b_lvl_i);
      end
      MODE_ENC_AB: begin
        step_raw = a_edge ^ b_edge;
        down_o   = a_edge ? ~a_edge_up(a_lvl_i, b_lvl_i)
                          : ~b_edge_up(a_lvl_i, b_lvl_i);
      end
      MODE_TRIG_CLR: begin
        step_raw = 1'b1;
        clear_o  = a_rise_i;
      end
      MODE_EXT_CLK: begin
        step_raw = a_rise_i;
      end
      default: begin
        step_raw = 1'b1;
      end
    endcase
  end

  assign step_o = step_raw & run_en_o;

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             down_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_down_o,
  output logic             update_o
);

  // Returns {wrapped, next value}.
  function automatic logic [CNT_W:0] next_val(input logic [CNT_W-1:0] cur,
                                               input logic [CNT_W-1:0] lim,
                                               input logic             dn);
    if (dn) begin
      if (cur == '0) return {1'b1, lim};
      return {1'b0, cur - CNT_W'(1)};
    end
    if (cur >= lim) return {1'b1, {CNT_W{1'b0}}};
    return {1'b0, cur + CNT_W'(1)};
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             dir_q;
  logic             upd_q;
  logic [CNT_W:0]   nxt;

  assign nxt = next_val(cnt_q, limit_i, down_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (clear_i) begin
        cnt_q <= '0;
        upd_q <= 1'b1;
      end else if (step_i) begin
        cnt_q <= nxt[CNT_W-1:0];
        upd_q <= nxt[CNT_W];
        dir_q <= down_i;
      end
    end
  end

  assign count_o    = cnt_q;
  assign dir_down_o = dir_q;
  assign update_o   = upd_q;

endmodule

// File: rtl/qenc_timer.sv
module qenc_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch_a_i,
  input  logic             ch_b_i,
  input  logic             inv_a_i,
  input  logic             inv_b_i,
  input  logic             cnt_en_i,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_down_o,
  output logic             update_o
);

  logic a_lvl, a_rise, a_fall;
  logic b_lvl, b_rise, b_fall;
  logic run_en, step_req, step_down, clear_req;

  qenc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst_n(rst_n), .pin_i(ch_a_i), .inv_i(inv_a_i),
    .lvl_o(a_lvl), .rise_o(a_rise), .fall_o(a_fall)
  );

  qenc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst_n(rst_n), .pin_i(ch_b_i), .inv_i(inv_b_i),
    .lvl_o(b_lvl), .rise_o(b_rise), .fall_o(b_fall)
  );

  qenc_decode u_decode (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cnt_en_i(cnt_en_i),
    .a_lvl_i(a_lvl), .a_rise_i(a_rise), .a_fall_i(a_fall),
    .b_lvl_i(b_lvl), .b_rise_i(b_rise), .b_fall_i(b_fall),
    .run_en_o(run_en), .step_o(step_req), .down_o(step_down), .clear_o(clear_req)
  );

  qenc_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .step_i(step_req), .down_i(step_down),
    .clear_i(clear_req), .limit_i(reload_i),
    .count_o(count_o), .dir_down_o(dir_down_o), .update_o(update_o)
  );

endmodule

// File: rtl/qenc_timer_chk.sv
module qenc_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode_i,
  input logic [CNT_W-1:0] reload_i,
  input logic [CNT_W-1:0] count_o,
  input logic             dir_down_o,
  input logic             update_o,
  input logic             a_rise,
  input logic             a_fall,
  input logic             b_rise,
  input logic             b_fall,
  input logic             run_en,
  input logic             step_req,
  input logic             step_down,
  input logic             clear_req
);

  logic enc_mode;
  assign enc_mode = (mode_i == 3'b001) || (mode_i == 3'b010) || (mode_i == 3'b011);

  a_r4_no_double_step: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_mode && (a_rise || a_fall) && (b_rise || b_fall)) |-> !step_req);

  a_r5_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !step_down && !clear_req && count_o == reload_i)
      |=> (count_o == '0 && update_o));

  a_r5_update_value: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |-> (count_o == '0 || count_o == $past(reload_i)));

  a_r6_dir_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !step_down && !clear_req) |=> !dir_down_o);

  a_r6_dir_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && step_down && !clear_req) |=> dir_down_o);

  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !clear_req) |=> $stable(count_o));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear_req |=> (count_o == '0 && update_o));

endmodule

bind qenc_timer qenc_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .reload_i(reload_i),
  .count_o(count_o), .dir_down_o(dir_down_o), .update_o(update_o),
  .a_rise(a_rise), .a_fall(a_fall), .b_rise(b_rise), .b_fall(b_fall),
  .run_en(run_en), .step_req(step_req), .step_down(step_down),
  .clear_req(clear_req)
);

// File: tb/qenc_timer_tb_top.sv
`timescale 1ns/1ps
module qenc_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pa, pb, inv_a, inv_b, en;
  logic [2:0]  mode;
  logic [15:0] reload;
  logic [15:0] count;
  logic        dir_down, upd;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    string       req;
    logic [15:0] cnt;
    logic        dir;
    logic        upd;
  } exp_t;

  exp_t sb_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  qenc_timer dut_i (
    .clk(clk), .rst_n(rst_n), .ch_a_i(pa), .ch_b_i(pb),
    .inv_a_i(inv_a), .inv_b_i(inv_b), .cnt_en_i(en), .mode_i(mode),
    .reload_i(reload), .count_o(count), .dir_down_o(dir_down), .update_o(upd)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(input int d, input string r, input logic [15:0] c,
                           input logic dv, input logic uv);
    exp_t e;
    e.due = cyc + d; e.req = r; e.cnt = c; e.dir = dv; e.upd = uv;
    sb_q.push_back(e);
  endtask

  task automatic pins(input logic a, input logic b, input string r,
                      input logic [15:0] c, input logic dv, input logic uv);
    pa = a; pb = b;
    expect_at(3, r, c, dv, uv);
    tick(4);
  endtask

  // Monitor: compare each item exactly on its due cycle.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
        exp_t it;
        it = sb_q.pop_front();
        checks++;
        if (it.due != cyc || count !== it.cnt || dir_down !== it.dir || upd !== it.upd) begin
          errors++;
          $display("FAIL %s cycle %0d due %0d: count=%h dir=%b upd=%b expected count=%h dir=%b upd=%b",
                   it.req, cyc, it.due, count, dir_down, upd, it.cnt, it.dir, it.upd);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pa = 0; pb = 0; inv_a = 0; inv_b = 0; en = 0;
    mode = 3'b011; reload = 16'hFFFF;
    tick(3);
    rst_n = 1'b1;
    expect_at(1, "R1", 16'h0000, 0, 0);
    tick(2);

    // R2: x4 forward sequence
    en = 1; tick(1);
    pins(1, 0, "R2", 16'd1, 0, 0);
    pins(1, 1, "R2", 16'd2, 0, 0);
    pins(0, 1, "R2", 16'd3, 0, 0);
    pins(0, 0, "R2", 16'd4, 0, 0);
    // R6: reverse sequence
    pins(0, 1, "R6", 16'd3, 1, 0);
    pins(1, 1, "R6", 16'd2, 1, 0);
    pins(1, 0, "R6", 16'd1, 1, 0);
    pins(0, 0, "R6", 16'd0, 1, 0);
    // R5: wrap down and up at full range
    pins(0, 1, "R5", 16'hFFFF, 1, 1);
    pins(0, 0, "R5", 16'h0000, 0, 1);
    // R4: both lines change together
    pins(1, 1, "R4", 16'h0000, 0, 0);
    pins(0, 0, "R4", 16'h0000, 0, 0);

    // R3: x2 on A
    mode = 3'b001; tick(2);
    pins(0, 1, "R3", 16'h0000, 0, 0);
    pins(1, 1, "R3", 16'hFFFF, 1, 1);
    pins(1, 0, "R3", 16'hFFFF, 1, 0);
    pins(0, 0, "R3", 16'hFFFE, 1, 0);
    // R3: x2 on B
    mode = 3'b010; tick(2);
    pins(0, 1, "R3", 16'hFFFD, 1, 0);
    pins(1, 1, "R3", 16'hFFFD, 1, 0);
    pins(1, 0, "R3", 16'hFFFC, 1, 0);
    pins(1, 1, "R3", 16'hFFFD, 0, 0);
    pins(0, 1, "R3", 16'hFFFD, 0, 0);
    pins(0, 0, "R3", 16'hFFFE, 0, 0);

    // R7: disabled encoder ignores edges
    mode = 3'b011; en = 0; tick(2);
    pins(1, 0, "R7", 16'hFFFE, 0, 0);
    pins(0, 0, "R7", 16'hFFFE, 0, 0);

    // R8: clear while disabled, then while free-running
    mode = 3'b100; tick(2);
    pins(1, 0, "R8", 16'h0000, 0, 1);
    expect_at(1, "R8", 16'h0000, 0, 0);
    tick(2);
    pins(0, 0, "R8", 16'h0000, 0, 0);
    en = 1;
    expect_at(5, "R8", 16'd5, 0, 0);
    tick(6);
    pa = 1;
    expect_at(3, "R8", 16'd0, 0, 1);
    expect_at(4, "R8", 16'd1, 0, 0);
    tick(4);
    en = 0; pa = 0;
    expect_at(3, "R7", 16'd1, 0, 0);
    tick(4);

    // R9: trigger start
    mode = 3'b110; tick(2);
    expect_at(2, "R9", 16'd1, 0, 0);
    tick(3);
    pa = 1;
    expect_at(3, "R9", 16'd1, 0, 0);
    expect_at(4, "R9", 16'd2, 0, 0);
    expect_at(8, "R9", 16'd6, 0, 0);
    tick(8);
    mode = 3'b011;
    expect_at(3, "R9", 16'd6, 0, 0);
    tick(4);

    // R10: external clock on A rising edges
    mode = 3'b111; en = 1; tick(2);
    pins(0, 0, "R10", 16'd6, 0, 0);
    pins(1, 0, "R10", 16'd7, 0, 0);
    pins(0, 0, "R10", 16'd7, 0, 0);

    // R11: inverted A counts on pin falls
    en = 0; inv_a = 1;
    expect_at(4, "R11", 16'd7, 0, 0);
    tick(5);
    en = 1; tick(1);
    pins(1, 0, "R11", 16'd7, 0, 0);
    pins(0, 0, "R11", 16'd8, 0, 0);
    en = 0; inv_a = 0; tick(4);

    // R12: free count in code 101
    mode = 3'b101; tick(1);
    en = 1;
    expect_at(3, "R12", 16'd11, 0, 0);
    tick(3);
    en = 0;
    expect_at(2, "R12", 16'd11, 0, 0);
    tick(3);

    // R5: small limit, wrap up in code 000
    mode = 3'b100; tick(1);
    pins(1, 0, "R8", 16'd0, 0, 1);
    pins(0, 0, "R8", 16'd0, 0, 0);
    mode = 3'b000; reload = 16'd3; tick(1);
    en = 1;
    expect_at(3, "R5", 16'd3, 0, 0);
    expect_at(4, "R5", 16'd0, 0, 1);
    expect_at(5, "R5", 16'd1, 0, 0);
    tick(5);
    en = 0;

    // R5: small limit, wrap down in x4 mode
    mode = 3'b011; en = 1; tick(1);
    pins(1, 0, "R2", 16'd2, 0, 0);
    pins(0, 0, "R6", 16'd1, 1, 0);
    pins(0, 1, "R6", 16'd0, 1, 0);
    pins(1, 1, "R5", 16'd3, 1, 1);

    tick(3);
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL all: pending=%0d expected=0", sb_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule